// File: doc/BRIEF.md
# Double-Buffered PWM Generator with 10-bit Duty Resolution

This block drives a single pulse-width-modulated output. An 8-bit timer counts up to a programmable period value and then restarts. Two fine bits sit below the timer, so the time base has 10 bits. With a prescale factor of 1 the fine bits come from a free-running 2-bit phase counter. With a factor of 4 or 16 they come from the prescaler counter. The output rises when a period starts. It falls when the 10-bit time base reaches the active duty value.

Software programs the block through a small write and read register port. It sets a period byte, a coarse duty byte, and a control byte. The control byte holds the two fine duty bits, the prescale select and the mode enable. The duty value written by software is held in a shadow register. It is copied into the shadow only at a period boundary, so a duty change never cuts a pulse short or stretches it. Software can read back the shadow, but cannot write it.

Top module: `pwm_dbuf_gen`

## Requirements
- R1: After synchronous reset, `pwm_out` is 0 and all four read addresses return 0.
- R2: With period byte P and prescale factor S, the output repeats every (P+1)·4·S clock cycles, with exactly one rising edge per period whenever the duty is nonzero and shorter than the period.
- R3: The duty value D is {coarse byte, fine bits}, where the coarse byte is the upper eight bits. The output stays high for D·S cycles from the start of each period.
- R4: Control bits [3:2] select the prescale factor: 00 gives 1, 01 gives 4, and 10 or 11 gives 16.
- R5: Writes to the coarse byte or the fine bits during a period do not change that period's pulse. The new duty takes effect from the next period onward.
- R6: If the duty loaded at a period boundary is zero, the output stays low for that whole period.
- R7: If the duty exceeds the last time-base value of the period, the output never falls and stays high for the full period.
- R8: Writing the control byte with enable bit [4] at 0 drives `pwm_out` low from the next cycle and restarts the time base from zero. After the block is enabled again, the output stays low for the first period until the first period boundary.
- R9: Read address 3 returns the upper eight shadow duty bits. Control readback bits [7:6] return the two lower shadow bits. Writes to address 3 have no effect.
- R10: Address 0 holds the period byte, address 1 holds the coarse duty byte, and address 2 holds the control byte. Bits [4:0] of the control byte read back as they were written, and bit 5 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Combinational read data |
| pwm_out | output | 1 | PWM output |

## Verification
The properties assume that a write arriving in the same cycle as a period boundary only ever clears the enable, which is the one case excluded from the set-at-boundary check. They also assume that the period byte is not rewritten while the timer is above the new value. The directed tasks keep to these assumptions. They do all configuration while the block is disabled. They then align every measurement window to the restart that enabling causes. The one write made during a running period changes only the coarse duty byte, and it lands well clear of any boundary.

// File: rtl/pwm_dbuf_pkg.sv
`timescale 1ns/1ps
package pwm_dbuf_pkg;

    localparam int TMR_W   = 8;
    localparam int FINE_W  = 2;
    localparam int DUTY_W  = TMR_W + FINE_W;
    localparam int ADDR_W  = 2;
    localparam int DATA_W  = 8;

    // register addresses
    localparam logic [ADDR_W-1:0] ADR_PERIOD = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_COARSE = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_CTRL   = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_SHADOW = 2'd3;

    // control byte layout
    localparam int CTRL_FINE_LSB = 0;
    localparam int CTRL_PSEL_LSB = 2;
    localparam int CTRL_EN_BIT   = 4;
    localparam int CTRL_SHF_LSB  = 6;

    typedef enum logic [1:0] {
        PS_DIV1   = 2'b00,
        PS_DIV4   = 2'b01,
        PS_DIV16  = 2'b10,
        PS_DIV16B = 2'b11
    } psel_e;

    typedef struct packed {
        logic [TMR_W-1:0]  period;
        logic [TMR_W-1:0]  coarse;
        logic [FINE_W-1:0] fine;
        psel_e             psel;
        logic              en;
    } cfg_t;

endpackage

// File: rtl/pwm_regs.sv
`timescale 1ns/1ps
module pwm_regs
    import pwm_dbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DUTY_W-1:0] shadow,
    output cfg_t              cfg
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            unique case (wr_addr)
                ADR_PERIOD: cfg_d.period = wr_data;
                ADR_COARSE: cfg_d.coarse = wr_data;
                ADR_CTRL: begin
                    cfg_d.fine = wr_data[CTRL_FINE_LSB +: FINE_W];
                    cfg_d.psel = psel_e'(wr_data[CTRL_PSEL_LSB +: 2]);
                    cfg_d.en   = wr_data[CTRL_EN_BIT];
                end
                default: ; // shadow address is read-only
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_d;
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADR_PERIOD: rd_data = cfg_q.period;
            ADR_COARSE: rd_data = cfg_q.coarse;
            ADR_CTRL: begin
                rd_data[CTRL_FINE_LSB +: FINE_W] = cfg_q.fine;
                rd_data[CTRL_PSEL_LSB +: 2]      = cfg_q.psel;
                rd_data[CTRL_EN_BIT]             = cfg_q.en;
                rd_data[CTRL_SHF_LSB +: FINE_W]  = shadow[FINE_W-1:0];
            end
            default: rd_data = shadow[DUTY_W-1:FINE_W];
        endcase
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase
    import pwm_dbuf_pkg::*;
#(
    parameter int TW = TMR_W,
    parameter int FW = FINE_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  psel_e          psel,
    input  logic [TW-1:0]  period,
    output logic [TW-1:0]  timer,
    output logic [TW+FW-1:0] tb_nxt,
    output logic           wrap
);

    localparam int PW = 2 * FW;

    typedef struct packed {
        logic [FW-1:0] phase;
        logic [PW-1:0] pre;
        logic [TW-1:0] tmr;
    } tb_t;

    tb_t st_d, st_q;
    logic q_end;
    logic tick;

    function automatic logic [FW-1:0] fine_of(tb_t s, psel_e p);
        unique case (p)
            PS_DIV1: fine_of = s.phase;
            PS_DIV4: fine_of = s.pre[FW-1:0];
            default: fine_of = s.pre[PW-1:FW];
        endcase
    endfunction

    always_comb begin
        st_d  = st_q;
        q_end = (st_q.phase == '1);
        tick  = 1'b0;
        wrap  = 1'b0;
        if (!en) begin
            st_d = '0;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
            if (q_end) st_d.pre = st_q.pre + 1'b1;
            unique case (psel)
                PS_DIV1: tick = q_end;
                PS_DIV4: tick = q_end && (st_q.pre[FW-1:0] == '1);
                default: tick = q_end && (st_q.pre == '1);
            endcase
            if (tick) begin
                if (st_q.tmr == period) begin
                    wrap     = 1'b1;
                    st_d.tmr = '0;
                end else begin
                    st_d.tmr = st_q.tmr + 1'b1;
                end
            end
        end
        tb_nxt = {st_d.tmr, fine_of(st_d, psel)};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign timer = st_q.tmr;

endmodule

// File: rtl/pwm_duty.sv
`timescale 1ns/1ps
module pwm_duty
    import pwm_dbuf_pkg::*;
#(
    parameter int DW = DUTY_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          wrap,
    input  logic [DW-1:0] tb_nxt,
    input  logic [DW-1:0] duty_req,
    output logic [DW-1:0] shadow,
    output logic          out
);

    typedef struct packed {
        logic [DW-1:0] shd;
        logic          lvl;
    } dst_t;

    dst_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!en) begin
            s_d.lvl = 1'b0;
        end else begin
            if (wrap) begin
                s_d.shd = duty_req;
                s_d.lvl = (duty_req != '0);
            end
            // fall on the cycle the time base reaches the duty value
            if (tb_nxt == s_d.shd) s_d.lvl = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign shadow = s_q.shd;
    assign out    = s_q.lvl;

endmodule

// File: rtl/pwm_dbuf_gen.sv
`timescale 1ns/1ps
module pwm_dbuf_gen
    import pwm_dbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              pwm_out
);

    cfg_t              cfg;
    logic [TMR_W-1:0]  tb_timer;
    logic [DUTY_W-1:0] tb_nxt;
    logic              tb_wrap;
    logic [DUTY_W-1:0] duty_req;
    logic [DUTY_W-1:0] duty_shadow;
    logic              out_lvl;

    assign duty_req = {cfg.coarse, cfg.fine};

    pwm_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .shadow  (duty_shadow),
        .cfg     (cfg)
    );

    pwm_timebase #(.TW(TMR_W), .FW(FINE_W)) u_tb (
        .clk    (clk),
        .rst    (rst),
        .en     (cfg.en),
        .psel   (cfg.psel),
        .period (cfg.period),
        .timer  (tb_timer),
        .tb_nxt (tb_nxt),
        .wrap   (tb_wrap)
    );

    pwm_duty #(.DW(DUTY_W)) u_duty (
        .clk      (clk),
        .rst      (rst),
        .en       (cfg.en),
        .wrap     (tb_wrap),
        .tb_nxt   (tb_nxt),
        .duty_req (duty_req),
        .shadow   (duty_shadow),
        .out      (out_lvl)
    );

    assign pwm_out = out_lvl & cfg.en;

endmodule

// File: rtl/pwm_dbuf_chk.sv
`timescale 1ns/1ps
module pwm_dbuf_chk
    import pwm_dbuf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              off_req,
    input logic              pwm_out,
    input logic              wrap,
    input logic [DUTY_W-1:0] duty_req,
    input logic [DUTY_W-1:0] shadow,
    input logic [TMR_W-1:0]  timer
);

    AST_RESET_LOW: assert property (@(posedge clk)
        rst |=> !pwm_out);                                              // R1

    AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (timer == '0));                                        // R2

    AST_SET_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (wrap && duty_req != '0 && !off_req) |=> pwm_out);              // R3

    AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (shadow == $past(duty_req)));                          // R5

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(shadow));                                     // R5

    AST_ZERO_NO_SET: assert property (@(posedge clk) disable iff (rst)
        (wrap && duty_req == '0) |=> !pwm_out);                         // R6

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        off_req |=> !pwm_out);                                          // R8

endmodule

bind pwm_dbuf_gen pwm_dbuf_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .off_req  (wr_en && (wr_addr == pwm_dbuf_pkg::ADR_CTRL) && !wr_data[pwm_dbuf_pkg::CTRL_EN_BIT]),
    .pwm_out  (pwm_out),
    .wrap     (tb_wrap),
    .duty_req (duty_req),
    .shadow   (duty_shadow),
    .timer    (tb_timer)
);

// File: tb/sim_pwm_dbuf_gen.sv
`timescale 1ns/1ps
module sim_pwm_dbuf_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       pwm_out;

    int n_chk  = 0;
    int n_fail = 0;
    logic prev_out = 1'b0;

    always #2.5 clk = ~clk;

    pwm_dbuf_gen u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pwm_out(pwm_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input int exp);
        rd_addr = a;
        #1;
        check(req, int'(rd_data), exp);
    endtask

    task automatic window(input int n, output int hi, output int rises);
        hi = 0; rises = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
            if (pwm_out && !prev_out) rises++;
            prev_out = pwm_out;
        end
    endtask

    // configure while disabled, then enable; returns in the first enabled cycle
    task automatic setup(input int p, input int coarse, input int fine, input int ps);
        wr(2'd2, 8'(ps << 2));
        wr(2'd0, 8'(p));
        wr(2'd1, 8'(coarse));
        wr(2'd2, 8'((1 << 4) | (ps << 2) | fine));
        prev_out = pwm_out;
    endtask

    task automatic t_reset();
        check("R1 out", int'(pwm_out), 0);
        for (int a = 0; a < 4; a++) rd_chk("R1 readback", 2'(a), 0);
    endtask

    task automatic t_basic();
        int hi, r;
        setup(9, 5, 2, 0);                 // L = 40, D = 22
        window(39, hi, r);
        check("R8 first period low", hi, 0);
        window(40, hi, r);
        check("R3 high time", hi, 22);
        check("R2 one rise", r, 1);
        window(40, hi, r);
        check("R2 period repeat", hi, 22);
        check("R2 rise repeat", r, 1);
        rd_chk("R10 period", 2'd0, 9);
        rd_chk("R10 coarse", 2'd1, 5);
        rd_chk("R9 ctrl with shadow fine", 2'd2, 'h92);
        rd_chk("R9 shadow coarse", 2'd3, 5);
    endtask

    task automatic t_dbuf();
        int h1, h2, r;
        setup(9, 5, 2, 0);
        window(39, h1, r);
        fork
            window(40, h1, r);
            begin
                repeat (3) @(negedge clk);
                wr(2'd1, 8'd2);             // new D = 10
            end
        join
        check("R5 current period unchanged", h1, 22);
        window(40, h2, r);
        check("R5 new duty next period", h2, 10);
        wr(2'd3, 8'hAA);
        rd_chk("R9 shadow write ignored", 2'd3, 2);
        rd_chk("R9 coarse untouched", 2'd1, 2);
        rd_chk("R9 period untouched", 2'd0, 9);
    endtask

    task automatic t_zero();
        int hi, r;
        setup(3, 0, 0, 0);                 // L = 16
        window(15, hi, r);
        window(32, hi, r);
        check("R6 zero duty", hi, 0);
    endtask

    task automatic t_long();
        int hi, r;
        setup(3, 8, 0, 0);                 // D = 32 > 15
        window(15, hi, r);
        window(32, hi, r);
        check("R7 always high", hi, 32);
        check("R7 single rise", r, 1);
    endtask

    task automatic t_presc();
        int hi, r;
        setup(2, 1, 1, 1);                 // S = 4, L = 48, D = 5
        window(47, hi, r);
        window(48, hi, r);
        check("R4 div4 high", hi, 20);
        check("R4 div4 rise", r, 1);
        setup(1, 0, 3, 3);                 // S = 16, L = 128, D = 3
        window(127, hi, r);
        window(128, hi, r);
        check("R4 div16 high", hi, 48);
        check("R4 div16 rise", r, 1);
    endtask

    task automatic t_off();
        int hi, r;
        setup(9, 7, 2, 0);                 // D = 30
        window(39, hi, r);
        window(5, hi, r);
        check("R8 high before off", hi, 5);
        wr(2'd2, 8'h02);
        check("R8 low after off", int'(pwm_out), 0);
        window(10, hi, r);
        check("R8 stays low", hi, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_dbuf();
        t_zero();
        t_long();
        t_presc();
        t_off();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule